// File: doc/BRIEF.md
# Compare Match Output Pin Unit

This block keeps the output-compare state bit for each timer channel and decides what the channel's I/O pin carries. The timer sends a one-cycle match strobe. Software can raise a force strobe that acts like a match. A two-bit mode field chooses what either event does to the state bit, and the same field chooses the pin's source. While the mode is nonzero, the pin carries the state bit in place of the general port data bit. The port direction bit alone decides whether the pin is driven.

Each channel's state bit is a two-state machine with the states `OC_LOW` and `OC_HIGH`. On every clock edge the machine takes one of four transitions:

- `HOLD`: no event, or mode 00.
- `TOGGLE`: an event with mode 01.
- `CLEAR`: an event with mode 10, which goes to `OC_LOW`.
- `SET`: an event with mode 11, which goes to `OC_HIGH`.

The mode field has no buffer. Its value at a clock edge picks the transition, and its current value selects the pin source straight away. Because direction is never overridden, software can force the state while the pin is still an input. The preset value then appears as soon as the direction bit turns the driver on.

Top module: `cmpout_unit`

## Requirements
- R1: While reset is active, every state bit is 0 (`OC_LOW`). A pin whose mode is nonzero then reads 0.
- R2: An event (match or force) with mode 01 inverts the state bit at that clock edge.
- R3: An event with mode 10 makes the state bit 0.
- R4: An event with mode 11 makes the state bit 1.
- R5: With mode 00, or with no event, the state bit keeps its value.
- R6: A force strobe changes the state exactly as a match would under the same mode.
- R7: A match and a force in the same cycle count as one event. With mode 01 the bit inverts once.
- R8: If either mode bit is 1, the pin output equals the state bit. With mode 00 it equals the port data bit.
- R9: The pin output enable always equals the port direction bit (1 = output, 0 = high-impedance), whatever the mode.
- R10: A new mode value changes the pin source in the same cycle it is applied. At the next edge it selects the transition, with no extra delay.
- R11: A state value forced while direction is 0 appears on the pin once direction becomes 1.
- R12: The channels are independent; events and modes of one channel never change another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| match_i | input | CHANNELS | Per-channel compare match strobe |
| force_i | input | CHANNELS | Per-channel force-compare strobe |
| mode_i | input | 2*CHANNELS | Per-channel mode; channel k uses bits [2k+1:2k] |
| port_data_i | input | CHANNELS | General port data bit per pin |
| port_dir_i | input | CHANNELS | Port direction bit per pin, 1 = output |
| pin_o | output | CHANNELS | Value presented to each pin |
| pin_oe_o | output | CHANNELS | Pin driver enable |

## Verification
On every clock the assertions check the four state transitions: toggle, clear, set and hold. They also check that the pin source follows the mode and that the driver enable follows the direction bit. Only the bench scenarios can show the effects that span several steps. These are the preset-while-input sequence, the immediate effect of a mode change, single counting of a match that coincides with a force, the reset value, and independence between channels.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;
    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_TOGGLE = 2'b01,
        MODE_CLEAR  = 2'b10,
        MODE_SET    = 2'b11
    } cmp_mode_e;

    typedef enum logic {
        OC_LOW  = 1'b0,
        OC_HIGH = 1'b1
    } oc_state_e;

    localparam int MODE_W = 2;
endpackage

// File: rtl/cmpout_state_fsm.sv
module cmpout_state_fsm
    import cmpout_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_i,
    input  logic              force_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              state_o
);
    oc_state_e cur_q, nxt;
    cmp_mode_e mode;
    logic      evt;

    assign mode = cmp_mode_e'(mode_i);
    // a coincident match and force form one event
    assign evt  = match_i | force_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= OC_LOW;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        if (evt) begin
            unique case (mode)
                MODE_OFF:    nxt = cur_q;
                MODE_TOGGLE: nxt = (cur_q == OC_HIGH) ? OC_LOW : OC_HIGH;
                MODE_CLEAR:  nxt = OC_LOW;
                MODE_SET:    nxt = OC_HIGH;
                default:     nxt = cur_q;
            endcase
        end
    end

    always_comb state_o = (cur_q == OC_HIGH);

    p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode_i == 2'b01) |=> (state_o != $past(state_o)));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode_i == 2'b10) |=> !state_o);
    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode_i == 2'b11) |=> state_o);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt || mode_i == 2'b00) |=> $stable(state_o));
endmodule

// File: rtl/cmpout_pin_mux.sv
module cmpout_pin_mux
    import cmpout_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              state_i,
    input  logic              port_data_i,
    input  logic              port_dir_i,
    output logic              pin_o,
    output logic              oe_o
);
    logic override;

    always_comb begin
        override = (cmp_mode_e'(mode_i) != MODE_OFF);
        pin_o    = override ? state_i : port_data_i;
        oe_o     = port_dir_i;
    end

    p_src_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |-> (pin_o == port_data_i));
    p_src_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b00) |-> (pin_o == state_i));
    p_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o == port_dir_i);
endmodule

// File: rtl/cmpout_unit.sv
module cmpout_unit
    import cmpout_pkg::*;
#(
    parameter int CHANNELS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CHANNELS-1:0]        match_i,
    input  logic [CHANNELS-1:0]        force_i,
    input  logic [MODE_W*CHANNELS-1:0] mode_i,
    input  logic [CHANNELS-1:0]        port_data_i,
    input  logic [CHANNELS-1:0]        port_dir_i,
    output logic [CHANNELS-1:0]        pin_o,
    output logic [CHANNELS-1:0]        pin_oe_o
);
    logic [CHANNELS-1:0] state;

    for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
        cmpout_state_fsm i_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .match_i (match_i[k]),
            .force_i (force_i[k]),
            .mode_i  (mode_i[MODE_W*k +: MODE_W]),
            .state_o (state[k])
        );
        cmpout_pin_mux i_mux (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_i      (mode_i[MODE_W*k +: MODE_W]),
            .state_i     (state[k]),
            .port_data_i (port_data_i[k]),
            .port_dir_i  (port_dir_i[k]),
            .pin_o       (pin_o[k]),
            .oe_o        (pin_oe_o[k])
        );
    end

    // R1: first edge after reset release sees all states at 0
    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state == '0));
endmodule

// File: tb/test_cmpout_unit.sv
module test_cmpout_unit;
    localparam int  C       = 2;
    localparam time CLK_PER = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [C-1:0]   match = '0, frc = '0, pdata = '0, pdir = '0;
    logic [2*C-1:0] mode = '0;
    logic [C-1:0]   pin, oe;

    int n_run = 0, n_fail = 0;
    logic [C-1:0] mstate = '0;
    logic [C-1:0] q_pin[$];
    logic [C-1:0] q_oe[$];
    string        q_req[$];
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    cmpout_unit #(.CHANNELS(C)) i_cmpout_unit (
        .clk(clk), .rst_n(rst_n), .match_i(match), .force_i(frc),
        .mode_i(mode), .port_data_i(pdata), .port_dir_i(pdir),
        .pin_o(pin), .pin_oe_o(oe)
    );

    task automatic check(input logic [C-1:0] act, input logic [C-1:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // driver: drive at negedge, update model for the coming edge, push expectation
    task automatic step(input logic [C-1:0] m, input logic [C-1:0] f,
                        input logic [2*C-1:0] md, input logic [C-1:0] pd,
                        input logic [C-1:0] dr, input string req);
        logic [C-1:0] ep;
        @(negedge clk);
        match = m; frc = f; mode = md; pdata = pd; pdir = dr;
        for (int k = 0; k < C; k++) begin
            if (m[k] | f[k]) begin
                case (md[2*k +: 2])
                    2'b01: mstate[k] = ~mstate[k];
                    2'b10: mstate[k] = 1'b0;
                    2'b11: mstate[k] = 1'b1;
                    default: ;
                endcase
            end
            ep[k] = (md[2*k +: 2] != 2'b00) ? mstate[k] : pd[k];
        end
        q_pin.push_back(ep);
        q_oe.push_back(dr);
        q_req.push_back(req);
    endtask

    // monitor: a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PER/4);
            if (q_pin.size() > 0) begin
                logic [C-1:0] ep, eo;
                string r;
                ep = q_pin.pop_front();
                eo = q_oe.pop_front();
                r  = q_req.pop_front();
                check(pin, ep, {r, " pin"});
                check(oe, eo, {r, " oe"});
            end
        end
    end

    initial begin
        #(CLK_PER*100000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        mode = 4'b1111; pdir = 2'b11; pdata = 2'b11;
        repeat (3) @(posedge clk);
        #(CLK_PER/4);
        check(pin, 2'b00, "R1 reset pin");
        check(oe, 2'b11, "R1 reset oe");
        @(negedge clk);
        rst_n = 1'b1;
        // ch0 set, ch1 mode 00 shows port data (R8, R12)
        step(2'b01, 2'b00, 4'b0011, 2'b10, 2'b11, "R4 set");
        step(2'b01, 2'b00, 4'b0001, 2'b10, 2'b11, "R2 toggle");
        step(2'b00, 2'b01, 4'b0001, 2'b00, 2'b11, "R6 force");
        step(2'b01, 2'b01, 4'b0001, 2'b00, 2'b11, "R7 once");
        step(2'b01, 2'b00, 4'b0000, 2'b01, 2'b11, "R5 mode00");
        step(2'b00, 2'b00, 4'b0001, 2'b01, 2'b11, "R10 immediate");
        step(2'b00, 2'b01, 4'b0011, 2'b00, 2'b00, "R9 preset input");
        step(2'b00, 2'b00, 4'b0011, 2'b00, 2'b01, "R11 preset shown");
        step(2'b01, 2'b00, 4'b0010, 2'b01, 2'b01, "R3 clear");
        step(2'b10, 2'b00, 4'b1100, 2'b00, 2'b10, "R12 ch1 set");
        step(2'b00, 2'b00, 4'b0101, 2'b00, 2'b11, "R8 both override");
        for (int i = 0; i < 40; i++) begin
            step(C'(i * 5 + 1), C'(i / 3), 4'(i * 7 + 3), C'(i), C'(i * 3 + 1), "R12 mixed");
        end
        @(negedge clk);
        while (q_pin.size() > 0) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule